// File: doc/BRIEF.md
# Seven-to-One Display Link Serializer

This block turns a 28-bit parallel pixel word into four serial data lanes and one forwarded clock lane. Each pixel period it takes a word, splits it into four 7-bit slices and shifts each slice out on its own lane during the seven bit-clock cycles that follow. The forwarded clock lane carries a fixed 7-bit marker, so a receiver can find the slot boundaries. The word is taken on the rising or the falling pixel-clock edge, chosen by a select pin.

All logic runs on the 7x bit clock, which is phase-aligned to the pixel clock. The pixel clock is sampled as data and its edges are found by comparing it with its value one bit clock earlier. A gap counter watches for a stalled pixel clock. Power-down, a low clock-present input or a detected stall silences every lane at once. On restart only freshly captured words reach the lanes.

Top module: `pxlink_ser`

## Requirements
- R1: On each selected pixel-clock edge while the link runs, all 28 input bits are captured. The word is shifted out over the next seven bit clocks, and frames follow one another with no gap, so every captured word is sent.
- R2: Lane k carries word bits 7k+6 down to 7k. Bit 7k+6 goes out first and bit 7k goes out last.
- R3: The clock lane sends 1,1,0,0,0,1,1 in each frame. Its first bit goes out in the same bit clock as the first bit of every data lane.
- R4: When `edge_rise_sel` is 1 the word is captured on the rising pixel-clock edge. When it is 0 the word is captured on the falling edge.
- R5: When `pwr_dn_n` is low, every lane is low from the next bit clock on, and a frame that was being sent is dropped.
- R6: When `pix_clk_ok` is low, every lane is low from the next bit clock on, and a frame that was being sent is dropped.
- R7: After 16 bit clocks with no rising pixel-clock edge, the clock counts as lost and every lane is held low. A gap of 14 bit clocks (one missing pixel period) has no effect.
- R8: A rising edge counts as good when it comes less than 16 bit clocks after the previous one, so the first edge after an outage does not count. The lost state clears on the fourth good edge. In rising mode, the first word sent after the clock returns is the one captured at the sixth rising edge.
- R9: When `pwr_dn_n` or `pix_clk_ok` is raised, the first word sent is the one captured at the first selected edge at or after the release. No stale or partial word ever appears.
- R10: During reset every lane is low, and the pixel clock is treated as lost until R8 is met.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | 7x bit clock, phase-aligned to the pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_clk | input | 1 | Pixel clock, sampled on bit_clk |
| pix_clk_ok | input | 1 | External pixel-clock-present indication, high when present |
| pwr_dn_n | input | 1 | Active-low power-down |
| edge_rise_sel | input | 1 | 1 = capture on rising edge, 0 = on falling edge |
| pix_word | input | 28 | Parallel pixel word (24 colour, 3 timing, 1 spare) |
| lane_data | output | 4 | Serial data lanes |
| lane_clk | output | 1 | Forwarded clock lane |

## Verification
Two functions can fall in the same bit clock. Release from power-down or from a low clock-present input can coincide with a capture edge. An outage can start in the very bit clock that would carry a frame's last bit. The bench provokes both by changing the control pins in the bit clock that raises the pixel clock. A scoreboard then judges the outcome: it expects the release-edge word as the first frame, and it removes the word that was cut off from its queue. Any stale, shifted or partial frame that reaches the monitor shows up as a mismatch or as an unexpected frame.

// File: rtl/pxl_pkg.sv
package pxl_pkg;
    localparam int LANE_CNT  = 4;
    localparam int SLOT_CNT  = 7;
    localparam int GAP_MAX   = 16;
    localparam int GOOD_REQ  = 4;

    // marker for the forwarded clock: two high slots at each end, low between
    function automatic logic [31:0] marker_bits(input int width);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < width; i++) begin
            m[i] = (i >= width - 2) || (i < 2);
        end
        return m;
    endfunction
endpackage

// File: rtl/pxl_clk_watch.sv
module pxl_clk_watch #(
    parameter int GAP_LIMIT = 16,
    parameter int GOOD_NEED = 4
) (
    input  logic bit_clk,
    input  logic rst_n,
    input  logic pix_clk,
    input  logic rise_sel,
    output logic cap_stb,
    output logic clk_lost
);
    localparam int GW = $clog2(GAP_LIMIT + 1);
    localparam int CW = $clog2(GOOD_NEED + 1);

    typedef struct packed {
        logic          pix;
        logic [GW-1:0] gap;
        logic [CW-1:0] good;
        logic          lost;
    } watch_t;

    watch_t w_d, w_q;
    logic   rise_w, fall_w;

    always_comb begin
        w_d     = w_q;
        rise_w  = pix_clk & ~w_q.pix;
        fall_w  = ~pix_clk & w_q.pix;
        cap_stb = rise_sel ? rise_w : fall_w;
        w_d.pix = pix_clk;
        if (rise_w) begin
            w_d.gap = '0;
            if (w_q.lost) begin
                if (w_q.gap < GW'(GAP_LIMIT)) begin
                    if (w_q.good == CW'(GOOD_NEED - 1)) begin
                        w_d.lost = 1'b0;
                        w_d.good = '0;
                    end else begin
                        w_d.good = w_q.good + 1'b1;
                    end
                end else begin
                    w_d.good = '0;
                end
            end
        end else if (w_q.gap < GW'(GAP_LIMIT)) begin
            w_d.gap = w_q.gap + 1'b1;
            if (w_q.gap == GW'(GAP_LIMIT - 1)) begin
                w_d.lost = 1'b1;
                w_d.good = '0;
            end
        end
    end

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q.pix  <= 1'b0;
            w_q.gap  <= GW'(GAP_LIMIT);
            w_q.good <= '0;
            w_q.lost <= 1'b1;
        end else begin
            w_q <= w_d;
        end
    end

    assign clk_lost = w_q.lost;
endmodule

// File: rtl/pxl_capture.sv
module pxl_capture #(
    parameter int WORD_W = 28
) (
    input  logic              bit_clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic              run,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] word_out,
    output logic              load,
    output logic              tx_en
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              valid;
        logic              load;
        logic              en;
    } cap_t;

    cap_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (!run) begin
            c_d.valid = 1'b0;
            c_d.load  = 1'b0;
            c_d.en    = 1'b0;
        end else begin
            if (stb) begin
                c_d.word  = word_in;
                c_d.valid = 1'b1;
            end
            c_d.load = stb;
            if (c_q.load && c_q.valid) begin
                c_d.en = 1'b1;
            end
        end
    end

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign word_out = c_q.word;
    assign load     = c_q.load;
    assign tx_en    = c_q.en;
endmodule

// File: rtl/pxl_lane_shift.sv
module pxl_lane_shift #(
    parameter int W = 7
) (
    input  logic         bit_clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] par_in,
    output logic         ser_out
);
    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        if (clear) begin
            sh_d = '0;
        end else if (load) begin
            sh_d = par_in;
        end else begin
            sh_d = {sh_q[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign ser_out = sh_q[W-1];
endmodule

// File: rtl/pxlink_ser.sv
module pxlink_ser #(
    parameter int LANES     = pxl_pkg::LANE_CNT,
    parameter int SLOT_BITS = pxl_pkg::SLOT_CNT,
    parameter int GAP_LIMIT = pxl_pkg::GAP_MAX,
    parameter int GOOD_NEED = pxl_pkg::GOOD_REQ
) (
    input  logic                         bit_clk,
    input  logic                         rst_n,
    input  logic                         pix_clk,
    input  logic                         pix_clk_ok,
    input  logic                         pwr_dn_n,
    input  logic                         edge_rise_sel,
    input  logic [LANES*SLOT_BITS-1:0]   pix_word,
    output logic [LANES-1:0]             lane_data,
    output logic                         lane_clk
);
    localparam int WORD_W = LANES * SLOT_BITS;
    localparam logic [31:0] MARK_FULL = pxl_pkg::marker_bits(SLOT_BITS);
    localparam logic [SLOT_BITS-1:0] CLK_MARK = MARK_FULL[SLOT_BITS-1:0];

    logic              stb_w, lost_w, run_w, load_w, en_w, clk_ser_w;
    logic [WORD_W-1:0] word_w;
    logic [LANES-1:0]  ser_w;

    assign run_w = pwr_dn_n & pix_clk_ok & ~lost_w;

    pxl_clk_watch #(.GAP_LIMIT(GAP_LIMIT), .GOOD_NEED(GOOD_NEED)) u_watch (
        .bit_clk (bit_clk),
        .rst_n   (rst_n),
        .pix_clk (pix_clk),
        .rise_sel(edge_rise_sel),
        .cap_stb (stb_w),
        .clk_lost(lost_w)
    );

    pxl_capture #(.WORD_W(WORD_W)) u_cap (
        .bit_clk (bit_clk),
        .rst_n   (rst_n),
        .stb     (stb_w),
        .run     (run_w),
        .word_in (pix_word),
        .word_out(word_w),
        .load    (load_w),
        .tx_en   (en_w)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        pxl_lane_shift #(.W(SLOT_BITS)) u_sh (
            .bit_clk(bit_clk),
            .rst_n  (rst_n),
            .clear  (~run_w),
            .load   (load_w),
            .par_in (word_w[k*SLOT_BITS +: SLOT_BITS]),
            .ser_out(ser_w[k])
        );
    end

    pxl_lane_shift #(.W(SLOT_BITS)) u_clk_sh (
        .bit_clk(bit_clk),
        .rst_n  (rst_n),
        .clear  (~run_w),
        .load   (load_w),
        .par_in (CLK_MARK),
        .ser_out(clk_ser_w)
    );

    assign lane_data = ser_w & {LANES{en_w}};
    assign lane_clk  = clk_ser_w & en_w;
endmodule

module pxlink_ser_chk #(
    parameter int LANES = 4
) (
    input logic             bit_clk,
    input logic             rst_n,
    input logic             pwr_dn_n,
    input logic             pix_clk_ok,
    input logic [LANES-1:0] lane_data,
    input logic             lane_clk,
    input logic             lost,
    input logic             cap_stb,
    input logic             run,
    input logic             load,
    input logic             tx_en
);
    p_pd_quiet_r5: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !pwr_dn_n |=> (lane_data == '0 && !lane_clk));

    p_ok_quiet_r6: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !pix_clk_ok |=> (lane_data == '0 && !lane_clk));

    p_lost_quiet_r7: assert property (@(posedge bit_clk) disable iff (!rst_n)
        lost |=> (lane_data == '0 && !lane_clk));

    p_stb_load_r1: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (cap_stb && run) |=> load);

    p_en_after_run_r9: assert property (@(posedge bit_clk) disable iff (!rst_n)
        tx_en |-> $past(run));
endmodule

bind pxlink_ser pxlink_ser_chk #(.LANES(LANES)) u_chk (
    .bit_clk   (bit_clk),
    .rst_n     (rst_n),
    .pwr_dn_n  (pwr_dn_n),
    .pix_clk_ok(pix_clk_ok),
    .lane_data (lane_data),
    .lane_clk  (lane_clk),
    .lost      (lost_w),
    .cap_stb   (stb_w),
    .run       (run_w),
    .load      (load_w),
    .tx_en     (en_w)
);

// File: tb/pxlink_ser_test.sv
`timescale 1ns/1ps
module pxlink_ser_test;
    logic        bclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pclk = 1'b0;
    logic        ok_in = 1'b1;
    logic        pdn = 1'b1;
    logic        rsel = 1'b1;
    logic [27:0] din = '0;
    logic [3:0]  ld;
    logic        lc;

    int n_chk = 0;
    int n_fail = 0;
    int n_push = 0;
    int n_frames = 0;
    int gi = 0;
    logic [27:0] exp_q[$];

    always #2.5 bclk = ~bclk;

    pxlink_ser uut (
        .bit_clk(bclk), .rst_n(rst_n), .pix_clk(pclk), .pix_clk_ok(ok_in),
        .pwr_dn_n(pdn), .edge_rise_sel(rsel), .pix_word(din),
        .lane_data(ld), .lane_clk(lc)
    );

    task automatic check(input bit good, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s: %s act=%h exp=%h", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    function automatic logic [27:0] pat(input int i);
        logic [31:0] h;
        case (i)
            1: return 28'hFFFFFFF;
            2: return 28'h5555555;
            3: return 28'h0000040;
            4: return 28'h0000080;
            5: return 28'h8000000;
            6: return 28'h0000001;
            7: return 28'h0000000;
            default: begin
                h = i * 32'h9E3779B1;
                h = h ^ (h >> 13);
                return h[27:0];
            end
        endcase
    endfunction

    // one pixel period: word a while pixel clock high, word b while low
    task automatic run_period(input bit clk_on, input bit expect_it,
                              input logic pd_v, input logic ok_v);
        logic [27:0] a, b;
        a = pat(gi);
        b = pat(gi + 1);
        gi += 2;
        for (int ph = 0; ph < 7; ph++) begin
            @(negedge bclk);
            pclk = clk_on && (ph < 4);
            din  = (ph < 4) ? a : b;
            if (ph == 0) begin
                pdn   = pd_v;
                ok_in = ok_v;
                if (expect_it) begin
                    exp_q.push_back(rsel ? a : b);
                    n_push++;
                end
            end
            if (ph == 1 && !pd_v) check(ld == 4'h0 && lc == 1'b0, "R5",
                                        "lanes after power-down", {27'd0, lc, ld}, 32'h0);
            if (ph == 1 && !ok_v) check(ld == 4'h0 && lc == 1'b0, "R6",
                                        "lanes after clock-ok low", {27'd0, lc, ld}, 32'h0);
        end
    endtask

    // monitor: frames found by the clock-lane marker
    logic [6:0] hc;
    logic [6:0] hd [4];
    logic [27:0] got, want;
    always @(negedge bclk) begin
        if (!rst_n) begin
            hc = '0;
            for (int k = 0; k < 4; k++) hd[k] = '0;
        end else begin
            hc = {hc[5:0], lc};
            for (int k = 0; k < 4; k++) hd[k] = {hd[k][5:0], ld[k]};
            if (hc == 7'b1100011) begin
                got = {hd[3], hd[2], hd[1], hd[0]};
                n_frames++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected frame", {4'h0, got}, 32'h0);
                end else begin
                    want = exp_q.pop_front();
                    check(got == want, "R2", "frame word (R1 R3 R4)", {4'h0, got}, {4'h0, want});
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge bclk);
        check(1'b0, "R1", "watchdog expired", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        // R10: reset state
        repeat (4) @(negedge bclk);
        check(ld == 4'h0 && lc == 1'b0, "R10", "lanes in reset", {27'd0, lc, ld}, 32'h0);
        rst_n = 1'b1;
        // R10 / R8: clock treated as lost; sixth edge is first word
        for (int p = 0; p < 5; p++) run_period(1'b1, 1'b0, 1'b1, 1'b1);
        for (int p = 0; p < 12; p++) run_period(1'b1, 1'b1, 1'b1, 1'b1);
        // R7: a single missing period does not count as lost
        run_period(1'b0, 1'b0, 1'b1, 1'b1);
        for (int p = 0; p < 4; p++) run_period(1'b1, 1'b1, 1'b1, 1'b1);
        // R7: long stop -> lost, lanes low
        for (int p = 0; p < 3; p++) run_period(1'b0, 1'b0, 1'b1, 1'b1);
        check(ld == 4'h0 && lc == 1'b0, "R7", "lanes while clock lost", {27'd0, lc, ld}, 32'h0);
        // R8: recovery, first word at the sixth rising edge
        for (int p = 0; p < 5; p++) run_period(1'b1, 1'b0, 1'b1, 1'b1);
        for (int p = 0; p < 4; p++) run_period(1'b1, 1'b1, 1'b1, 1'b1);
        // R5: power-down cuts the frame in flight; switch to falling mode
        void'(exp_q.pop_back());
        n_push--;
        run_period(1'b1, 1'b0, 1'b0, 1'b1);
        rsel = 1'b0;
        run_period(1'b1, 1'b0, 1'b0, 1'b1);
        // R9 / R4: release together with the edge, falling capture
        for (int p = 0; p < 8; p++) run_period(1'b1, 1'b1, 1'b1, 1'b1);
        // R6: clock-ok low in falling mode
        void'(exp_q.pop_back());
        n_push--;
        for (int p = 0; p < 2; p++) run_period(1'b1, 1'b0, 1'b1, 1'b0);
        for (int p = 0; p < 6; p++) run_period(1'b1, 1'b1, 1'b1, 1'b1);
        // back to rising mode through power-down, R9 release on capture edge
        void'(exp_q.pop_back());
        n_push--;
        run_period(1'b1, 1'b0, 1'b0, 1'b1);
        rsel = 1'b1;
        for (int p = 0; p < 6; p++) run_period(1'b1, 1'b1, 1'b1, 1'b1);
        // drain
        @(negedge bclk);
        pclk = 1'b0;
        repeat (20) @(negedge bclk);
        check(exp_q.size() == 0, "R1", "words left unsent", exp_q.size(), 32'h0);
        check(n_frames == n_push, "R3", "frames found by clock marker", n_frames, n_push);
        finish_run();
    end
endmodule